// File: doc/BRIEF.md
# Loadable Binary Up-Counter with Cascade Carry

This block is a synchronous binary up-counter, four bits wide by default. It has a parallel load and a count enable. An active-low asynchronous clear forces the count to zero at once, whatever the clock is doing. On each rising edge the register does exactly one thing, chosen by a fixed priority: load the data input, step up by one, or keep its value.

The carry output goes high when the count is all ones and the count enable is high. Wider counters are built by cascading stages: the carry of a lower stage drives the count enable of the next stage, so that stage steps only on the edge where the lower stage wraps back to zero. Internally, bit i toggles only when every lower bit is 1 and counting is enabled. The count runs 0, 1, ... up to all ones and then returns to 0.

Top module: `loadable_counter`

## Requirements
- R1: While rst_ni is 0, value_o is 0 immediately, without waiting for a clock edge, and it stays 0 across clock edges.
- R2: With rst_ni at 1 and load_i at 1, value_o takes the value of data_i on the rising clock edge.
- R3: With rst_ni at 1, load_i at 0 and count_i at 1, value_o increases by one on each rising edge.
- R4: With load_i at 0 and count_i at 0, value_o keeps its value across rising edges.
- R5: carry_o is 1 exactly when value_o is all ones (15 at the default width) and count_i is 1. It is 0 when the value is all ones and count_i is 0.
- R6: On a rising edge where carry_o is 1 and load_i is 0, value_o wraps from all ones to 0.
- R7: When load_i and count_i are both 1, the load wins. This holds even when the value is all ones and carry_o is 1.
- R8: Clear wins over load and count. With rst_ni at 0, asserting load_i and count_i across a rising edge leaves value_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous clear |
| load_i | input | 1 | Synchronous parallel load, highest clocked priority |
| count_i | input | 1 | Count enable |
| data_i | input | WIDTH | Parallel load value |
| value_o | output | WIDTH | Current count |
| carry_o | output | 1 | High when the count is all ones and counting is enabled |

## Verification
The hardest case to reach is the edge where the value is all ones, carry_o is high, and load_i is also high. In that case the load must win over the wrap. Getting there means loading 15 first and then holding both controls high for one more edge, and the stimulus table does exactly that. A second corner case is the clear dropping away from a clock edge while a load is pending. The bench lowers rst_ni in the middle of a cycle and checks the output before the next edge. It then keeps load and count high under clear across an edge.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INCR = 2'd1,
    OP_LOAD = 2'd2
  } lbc_op_e;
endpackage

// File: rtl/lbc_ctrl.sv
module lbc_ctrl
  import lbc_pkg::*;
(
  input  logic    load_i,
  input  logic    count_i,
  output lbc_op_e op_o
);
  // load outranks count; clear is handled in the register
  always_comb begin
    if (load_i)       op_o = OP_LOAD;
    else if (count_i) op_o = OP_INCR;
    else              op_o = OP_HOLD;
  end

  always_comb begin
    assert_ctrl_priority_R7: assert (!(load_i && (op_o != OP_LOAD)));
  end
endmodule

// File: rtl/lbc_incr.sv
module lbc_incr #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] value_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] next_o,
  output logic             carry_o
);
  logic [WIDTH:0] chain;

  assign chain[0] = en_i;

  // bit i toggles only when all lower bits are ones
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign next_o[i]    = value_i[i] ^ chain[i];
    assign chain[i + 1] = chain[i] & value_i[i];
  end

  assign carry_o = chain[WIDTH];
endmodule

// File: rtl/lbc_reg.sv
module lbc_reg
  import lbc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lbc_op_e          op_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic [WIDTH-1:0] incr_val_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else begin
      unique case (op_i)
        OP_LOAD: q_o <= load_val_i;
        OP_INCR: q_o <= incr_val_i;
        default: q_o <= q_o;
      endcase
    end
  end

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD) |=> $stable(q_o));
endmodule

// File: rtl/loadable_counter.sv
module loadable_counter
  import lbc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             count_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] value_o,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] MaxVal = {WIDTH{1'b1}};

  lbc_op_e          op;
  logic [WIDTH-1:0] incr_val;

  lbc_ctrl u_ctrl (
    .load_i  (load_i),
    .count_i (count_i),
    .op_o    (op)
  );

  lbc_incr #(.WIDTH(WIDTH)) u_incr (
    .value_i (value_o),
    .en_i    (count_i),
    .next_o  (incr_val),
    .carry_o (carry_o)
  );

  lbc_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .load_val_i (data_i),
    .incr_val_i (incr_val),
    .q_o        (value_o)
  );

  assert_clear_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (value_o == '0));

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (value_o == $past(data_i)));

  assert_incr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && count_i) |=> (value_o == WIDTH'($past(value_o) + 1'b1)));

  assert_carry_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (count_i && (value_o == MaxVal)));

  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_o && !load_i) |=> (value_o == '0));
endmodule

// File: tb/loadable_counter_test.sv
`timescale 1ns/1ps
module loadable_counter_test;
  localparam int W = 4;
  localparam int NVEC = 12;
  localparam time HALF = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic         cnt = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] val;
  logic         carry;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #HALF clk = ~clk;

  loadable_counter #(.WIDTH(W)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .load_i  (load),
    .count_i (cnt),
    .data_i  (din),
    .value_o (val),
    .carry_o (carry)
  );

  // {load, count, data, expected value after edge, expected carry before edge}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 4'd5,  4'd5,  1'b0},  // R2 load
    {1'b0, 1'b1, 4'd0,  4'd6,  1'b0},  // R3 step
    {1'b0, 1'b0, 4'd9,  4'd6,  1'b0},  // R4 hold, data ignored
    {1'b1, 1'b1, 4'd14, 4'd14, 1'b0},  // R7 load over count
    {1'b0, 1'b1, 4'd0,  4'd15, 1'b0},  // R3 to all ones
    {1'b0, 1'b0, 4'd0,  4'd15, 1'b0},  // R5 carry gated off
    {1'b0, 1'b1, 4'd0,  4'd0,  1'b1},  // R5 carry, R6 wrap
    {1'b0, 1'b1, 4'd0,  4'd1,  1'b0},  // R3 after wrap
    {1'b1, 1'b1, 4'd15, 4'd15, 1'b0},  // R2 load all ones
    {1'b1, 1'b1, 4'd3,  4'd3,  1'b1},  // R7 load beats wrap
    {1'b0, 1'b1, 4'd0,  4'd4,  1'b0},  // R3
    {1'b1, 1'b0, 4'd0,  4'd0,  1'b0}   // R2 load zero
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 2 * HALF);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    #(3 * HALF);
    check("R1 reset value", val, 4'd0);
    check("R1 reset carry", W'(carry), 4'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {load, cnt, din} = VEC[i][10:5];
      #1;
      check($sformatf("R5 carry vec %0d", i), W'(carry), W'(VEC[i][0]));
      @(posedge clk);
      #5;
      check($sformatf("R2/R3/R4/R6/R7 value vec %0d", i), val, VEC[i][4:1]);
    end

    // full sweep 0..15..0 (R3, R6)
    @(negedge clk);
    load = 1'b0;
    cnt = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      @(posedge clk);
      #5;
      check("R3 sweep", val, W'(k));
    end

    // R1 async clear mid-cycle, load pending
    @(negedge clk);
    load = 1'b1;
    din = 4'd9;
    @(posedge clk);
    #5;
    check("R2 preload", val, 4'd9);
    #2;
    rst_n = 1'b0;
    #1;
    check("R1 async clear", val, 4'd0);

    // R8 clear overrides load and count across an edge
    cnt = 1'b1;
    @(posedge clk);
    #5;
    check("R8 clear beats load", val, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    load = 1'b0;
    @(posedge clk);
    #5;
    check("R3 resume after clear", val, 4'd1);

    finish_run();
  end
endmodule